// File: doc/BRIEF.md
# Receiver Electrical Idle Inference

This per-lane block decides that the far end of a serial link has gone electrically idle by watching the decoded symbol stream instead of measuring signal amplitude. A 3-bit select input tells the block which link-training substate the lane is in. Each substate has its own rule: a kind of activity the link must keep showing, and a window length within which that activity must appear. When a window runs out with no qualifying activity, the block raises its idle flag.

The symbol decoder drives single-cycle event strobes into the block. There is one strobe each for a flow-control update, a skip ordered set, a TS1/TS2 ordered set, an observed exit from electrical idle, and an electrical idle ordered set. Windows advance only on cycles where `tick_i` is high. The two symbol-time windows assume two 10-bit symbols per parallel clock, so 1280 UI is 64 cycles and 2000 UI is 100 cycles. The long 128 µs window is a cycle count set by a parameter.

The idle flag is registered. It stays high until qualifying activity is seen again or a new window begins.

Top module: `rx_idle_infer`

## Requirements
- R1: With select 3'b100, idle_o goes high after the edge that counts the LONG_CYC-th tick since the window restarted, provided no flow-control update or skip ordered set has arrived since the restart.
- R2: With select 3'b101, idle_o goes high after TS_CYC ticks (64 by default) with no TS1/TS2 strobe.
- R3: With select 3'b110, idle_o goes high after EXIT_CYC ticks (100 by default) with no idle-exit strobe.
- R4: With select 3'b111, idle_o goes high after LONG_CYC ticks with no idle-exit strobe.
- R5: A qualifying event for the current select restarts the window and clears idle_o at the same edge. Events that qualify only for other selects do not restart the window.
- R6: A change of the select value restarts the window and clears idle_o at that edge.
- R7: Select values 3'b000 to 3'b011 disable inference. idle_o is low one cycle later and stays low, whatever the event strobes do.
- R8: With a select in 3'b100 to 3'b111, an electrical idle ordered set strobe sets idle_o at the next edge. If a qualifying event arrives in the same cycle, the qualifying event takes priority and idle_o is cleared.
- R9: The idle-exit strobe does not clear idle_o and does not restart the window under select 3'b100 or 3'b101.
- R10: The window advances only on cycles with tick_i high. With tick_i held low, idle_o never rises from timeout.
- R11: While rst_ni is low, idle_o is low and the window is at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_sel_i | input | 3 | Training substate select |
| tick_i | input | 1 | Window advance enable |
| fc_upd_i | input | 1 | Flow-control update received |
| skp_i | input | 1 | Skip ordered set received |
| ts_i | input | 1 | TS1 or TS2 ordered set received |
| idle_exit_i | input | 1 | Exit from electrical idle observed |
| eios_i | input | 1 | Electrical idle ordered set detected |
| idle_o | output | 1 | Inferred electrical idle |

## Verification
The bench puts each select through each of the four activity strobes in the middle of a window. It checks the exact cycle idle_o rises, which catches an off-by-one window, a swapped window length, or a strobe routed to the wrong select. It checks that idle-exit strobes cannot release idle under the active and configuration selects; a design that treated them as activity would drop the flag early. It also tests the priority of a qualifying event over a same-cycle idle ordered set, which a design with the priority reversed would get wrong by holding idle high. Finally it checks that disabled selects ignore every strobe, and that a stalled tick freezes the window, which a design counting raw cycles would fail.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
  typedef enum logic [2:0] {
    SEL_ACTIVE   = 3'b100,
    SEL_CFG      = 3'b101,
    SEL_SPD_FAIL = 3'b110,
    SEL_LPBK     = 3'b111
  } idle_sel_e;
endpackage

// File: rtl/rx_idle_decode.sv
module rx_idle_decode
  import rx_idle_pkg::*;
#(
  parameter int LONG_CYC = 16000,
  parameter int TS_CYC   = 64,
  parameter int EXIT_CYC = 100,
  parameter int CW       = 14
) (
  input  logic [2:0]    sel_i,
  input  logic          fc_upd_i,
  input  logic          skp_i,
  input  logic          ts_i,
  input  logic          idle_exit_i,
  output logic          valid_o,
  output logic          qual_o,
  output logic [CW-1:0] limit_o
);
  always_comb begin
    valid_o = 1'b1;
    qual_o  = 1'b0;
    limit_o = CW'(LONG_CYC);
    case (sel_i)
      SEL_ACTIVE:   begin qual_o = fc_upd_i | skp_i; limit_o = CW'(LONG_CYC); end
      SEL_CFG:      begin qual_o = ts_i;             limit_o = CW'(TS_CYC);   end
      SEL_SPD_FAIL: begin qual_o = idle_exit_i;      limit_o = CW'(EXIT_CYC); end
      SEL_LPBK:     begin qual_o = idle_exit_i;      limit_o = CW'(LONG_CYC); end
      default:      valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int CW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && !restart_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= expire_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rx_idle_infer.sv
module rx_idle_infer #(
  parameter int LONG_CYC = 16000,
  parameter int TS_CYC   = 64,
  parameter int EXIT_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_sel_i,
  input  logic       tick_i,
  input  logic       fc_upd_i,
  input  logic       skp_i,
  input  logic       ts_i,
  input  logic       idle_exit_i,
  input  logic       eios_i,
  output logic       idle_o
);
  localparam int MAX_A  = (LONG_CYC > TS_CYC) ? LONG_CYC : TS_CYC;
  localparam int MAX_CYC = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
  localparam int CW = $clog2(MAX_CYC + 1);

  logic [2:0]    sel_q;
  logic          sel_chg, sel_valid, qual, restart, expire;
  logic [CW-1:0] limit;

  assign sel_chg = (mode_sel_i != sel_q);
  assign restart = sel_chg | ~sel_valid | qual;

  rx_idle_decode #(
    .LONG_CYC(LONG_CYC), .TS_CYC(TS_CYC), .EXIT_CYC(EXIT_CYC), .CW(CW)
  ) u_decode (
    .sel_i(mode_sel_i), .fc_upd_i(fc_upd_i), .skp_i(skp_i), .ts_i(ts_i),
    .idle_exit_i(idle_exit_i), .valid_o(sel_valid), .qual_o(qual), .limit_o(limit)
  );

  rx_idle_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .tick_i(tick_i),
    .limit_i(limit), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 3'b000;
      idle_o <= 1'b0;
    end else begin
      sel_q <= mode_sel_i;
      if (restart)              idle_o <= 1'b0;
      else if (eios_i | expire) idle_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_idle_infer_chk.sv
module rx_idle_infer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_sel_i,
  input logic       fc_upd_i,
  input logic       skp_i,
  input logic       ts_i,
  input logic       idle_exit_i,
  input logic       eios_i,
  input logic       expire_i,
  input logic       idle_o
);
  logic [2:0] prev_sel;
  logic       qual_c;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_sel <= 3'b000;
    else         prev_sel <= mode_sel_i;

  always_comb
    case (mode_sel_i)
      3'b100:         qual_c = fc_upd_i | skp_i;
      3'b101:         qual_c = ts_i;
      3'b110, 3'b111: qual_c = idle_exit_i;
      default:        qual_c = 1'b0;
    endcase

  a_r7_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sel_i[2] |=> !idle_o);

  a_r6_sel_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i != prev_sel) |=> !idle_o);

  a_r5_qual_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i[2] && qual_c) |=> !idle_o);

  a_r8_eios_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i[2] && mode_sel_i == prev_sel && eios_i && !qual_c) |=> idle_o);

  a_r1_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> ($past(eios_i) || $past(expire_i)));

  a_r9_exit_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == 3'b100 && prev_sel == 3'b100 && idle_o && idle_exit_i
     && !fc_upd_i && !skp_i) |=> idle_o);
endmodule

bind rx_idle_infer rx_idle_infer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_sel_i(mode_sel_i), .fc_upd_i(fc_upd_i),
  .skp_i(skp_i), .ts_i(ts_i), .idle_exit_i(idle_exit_i), .eios_i(eios_i),
  .expire_i(expire), .idle_o(idle_o)
);

// File: tb/rx_idle_infer_bench.sv
module rx_idle_infer_bench;
  localparam int LONG = 30;
  localparam int TSC  = 64;
  localparam int EXC  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic tick = 1'b1, fc = 1'b0, skp = 1'b0, ts = 1'b0, ex = 1'b0, eios = 1'b0;
  logic idle;
  int n_tot = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_idle_infer #(.LONG_CYC(LONG), .TS_CYC(TSC), .EXIT_CYC(EXC)) u_rx_idle_infer (
    .clk_i(clk), .rst_ni(rst_n), .mode_sel_i(sel), .tick_i(tick), .fc_upd_i(fc),
    .skp_i(skp), .ts_i(ts), .idle_exit_i(ex), .eios_i(eios), .idle_o(idle)
  );

  task automatic chk(input logic exp, input string req, input string what);
    n_tot++;
    if (idle !== exp) begin
      n_fail++;
      $display("FAIL %s %s: idle_o=%b expected %b", req, what, idle, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int lim_of(input logic [2:0] s);
    case (s)
      3'b100: return LONG;
      3'b101: return TSC;
      3'b110: return EXC;
      default: return LONG;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'b100: return "R1";
      3'b101: return "R2";
      3'b110: return "R3";
      default: return "R4";
    endcase
  endfunction

  // event k: 0 fc, 1 skp, 2 ts, 3 idle exit
  function automatic bit qualifies(input logic [2:0] s, input int k);
    case (s)
      3'b100: return (k == 0 || k == 1);
      3'b101: return (k == 2);
      default: return (k == 3);
    endcase
  endfunction

  task automatic pulse_ev(input int k);
    fc = (k == 0); skp = (k == 1); ts = (k == 2); ex = (k == 3);
    step(1);
    fc = 0; skp = 0; ts = 0; ex = 0;
  endtask

  // enter select s from a disabled select; restart edge is the next one
  task automatic enter(input logic [2:0] s);
    sel = 3'b000; step(1);
    sel = s; step(1);
  endtask

  initial begin
    step(3);
    chk(1'b0, "R11", "during reset");
    rst_n = 1'b1;
    step(2);
    chk(1'b0, "R11", "after reset");

    // plain windows per select, plus R6 clear on select change
    for (int m = 4; m < 8; m++) begin
      automatic logic [2:0] s = 3'(m);
      automatic int lim = lim_of(s);
      enter(s);
      step(lim - 1);
      chk(1'b0, tag_of(s), "one tick before window end");
      step(1);
      chk(1'b1, tag_of(s), "at window end");
      step(5);
      chk(1'b1, tag_of(s), "idle held");
      sel = (s == 3'b111) ? 3'b100 : s + 3'd1;
      step(1);
      chk(1'b0, "R6", "select change clears");
      step(lim_of(sel) - 1);
      chk(1'b0, "R6", "restarted window not yet over");
      step(1);
      chk(1'b1, "R6", "restarted window ends");
    end

    // every select against every activity strobe mid-window
    for (int m = 4; m < 8; m++) begin
      for (int k = 0; k < 4; k++) begin
        automatic logic [2:0] s = 3'(m);
        automatic int lim = lim_of(s);
        automatic bit q = qualifies(s, k);
        enter(s);
        step(5);
        pulse_ev(k);
        if (q) begin
          step(lim - 1);
          chk(1'b0, "R5", "qualifying event restarted window");
          step(1);
          chk(1'b1, "R5", "restarted window ends");
          pulse_ev(k);
          chk(1'b0, "R5", "qualifying event clears idle");
        end else begin
          step(lim - 7);
          chk(1'b0, (k == 3) ? "R9" : "R5", "foreign event, before end");
          step(1);
          chk(1'b1, (k == 3) ? "R9" : "R5", "foreign event did not restart");
        end
      end
    end

    // idle exit cannot release idle under 100 / 101
    for (int m = 4; m < 6; m++) begin
      automatic logic [2:0] s = 3'(m);
      enter(s);
      step(lim_of(s));
      pulse_ev(3);
      chk(1'b1, "R9", "idle exit ignored while idle");
    end

    // idle ordered set sets idle; qualifying event wins when coincident
    enter(3'b101);
    step(2);
    eios = 1; step(1); eios = 0;
    chk(1'b1, "R8", "idle ordered set sets idle");
    eios = 1; ts = 1; step(1); eios = 0; ts = 0;
    chk(1'b0, "R8", "qualifying event beats idle ordered set");
    step(TSC - 1);
    chk(1'b0, "R8", "window restarted by coincident event");
    step(1);
    chk(1'b1, "R8", "window ends after coincident event");

    // disabled selects ignore all strobes
    for (int m = 0; m < 4; m++) begin
      sel = 3'(m);
      eios = 1; step(1); eios = 0;
      chk(1'b0, "R7", "idle ordered set ignored when disabled");
      step(EXC + 5);
      chk(1'b0, "R7", "no timeout when disabled");
    end

    // tick gating
    enter(3'b101);
    tick = 0;
    step(3 * TSC);
    chk(1'b0, "R10", "no timeout without ticks");
    tick = 1;
    step(TSC - 1);
    chk(1'b0, "R10", "ticks resumed, before end");
    tick = 0; step(10);
    chk(1'b0, "R10", "paused near end");
    tick = 1; step(1);
    chk(1'b1, "R10", "last tick ends window");

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    step(150000);
    n_tot++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule